// File: doc/BRIEF.md
# Delayed Half-Period Square Wave Regenerator

This block turns a train of narrow, irregularly spaced input pulses into a square wave with close to 50% duty cycle. Output edges are spaced exactly like the input edges. It only looks at the rising edges of the input and records the time of each one from a free-running tick counter. The period that starts at an edge is known only once the following edge arrives, so every output pulse is issued a fixed latency after its own input edge. That latency is set to the longest allowed input period. The output goes high at that moment and goes low again after half of the measured interval.

Edges waiting for their output moment are held in order in a small ring of timestamps. More than one input edge can be in flight at once. The ring depth is derived from the ratio of the latency to the shortest allowed period. If an edge has no successor by the time its output is due, the interval is unknown and that output pulse is skipped. All timing is set by parameters in microseconds and a ticks-per-microsecond factor.

Top module: `pulse_regen`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `square_out` is low. Reset empties all pending edge records.
- R2: After reset, `square_out` stays low until two input rising edges have been recorded. A single edge on its own never produces an output pulse.
- R3: Let cycle k be the first clock edge at which `pulse_in` is sampled high after being low. `square_out` then rises at clock edge k + D + 2, where D = MAX_PERIOD_US × TICKS_PER_US. This holds whenever the next input rise follows within D ticks.
- R4: Let S be the tick count between an input rise and the next one. The output pulse stays high for exactly floor(S/2) clock cycles.
- R5: The spacing between two output rises equals the spacing between the input rises that produced them.
- R6: The input's high time and its falling edges have no effect. Pulses of any width of at least one cycle give the same output.
- R7: For an odd interval S, the high time is rounded down to (S − 1)/2 cycles.
- R8: If the next input rise arrives more than D ticks after an edge, the output pulse for that edge is suppressed. Later edges are handled normally.
- R9: Wrap-around of the internal tick counter does not change any measured interval or output timing.
- R10: An interval of exactly D ticks still produces an output pulse, with high time D/2.
- R11: Back-to-back periods at the shortest allowed period MIN_PERIOD_US × TICKS_PER_US are all regenerated, with no edge record lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous narrow-pulse input; only its rising edges are used |
| square_out | output | 1 | Registered regenerated square wave |

## Verification
The hardest case to reach is an edge whose output moment falls on the same cycle as the arrival of its successor. That is a period of exactly D ticks, which must still produce a pulse. Close to it is a period one tick longer, which must be suppressed. Directed pulses at exactly D and at D + 1 ticks cover both. A run of minimum-length periods fills the edge ring to its deepest point. A long random run of periods and widths carries the tick counter through several wrap-arounds.

// File: rtl/pr_pkg.sv
package pr_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  // Convert microseconds to clock ticks.
  function automatic int unsigned us_to_ticks(input int unsigned us, input int unsigned tpu);
    return us * tpu;
  endfunction

  // Edge records that can be outstanding: edges inside one latency window plus margin.
  function automatic int unsigned ring_depth(input int unsigned delay_t, input int unsigned min_t);
    return (delay_t / min_t) + 2;
  endfunction

endpackage

// File: rtl/pr_edge_sync.sv
module pr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

  // A detected rise lasts one cycle, however long the input stays high.
  p_single_rise_r6: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/pr_stamp_ring.sv
module pr_stamp_ring #(
  parameter int TSW   = 14,
  parameter int DEPTH = 4,
  parameter int CNTW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [TSW-1:0]  push_ts,
  input  logic            pop,
  output logic [TSW-1:0]  head_ts,
  output logic [TSW-1:0]  next_ts,
  output logic [CNTW-1:0] fill
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [TSW-1:0] mem [DEPTH];
  logic [PW-1:0]  wr_ptr;
  logic [PW-1:0]  rd_ptr;
  logic           accept;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign accept = push && ((fill < CNTW'(DEPTH)) || pop);

  // Storage without reset so it can map onto distributed or block memory.
  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_ts;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (pop)    rd_ptr <= bump(rd_ptr);
      fill <= fill + CNTW'(accept) - CNTW'(pop);
    end
  end

  assign head_ts = mem[rd_ptr];
  assign next_ts = mem[bump(rd_ptr)];

  // No edge record may be dropped for lack of space.
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    push |-> ((fill < CNTW'(DEPTH)) || pop));

  // The scheduler only retires records that exist.
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
    pop |-> (fill != '0));

endmodule

// File: rtl/pr_out_sched.sv
module pr_out_sched
  import pr_pkg::*;
#(
  parameter int          TSW         = 14,
  parameter int          CNTW        = 3,
  parameter int unsigned DELAY_TICKS = 2500,
  parameter int unsigned MIN_TICKS   = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TSW-1:0]  now,
  input  logic [CNTW-1:0] fill,
  input  logic [TSW-1:0]  head_ts,
  input  logic [TSW-1:0]  next_ts,
  input  logic            push,
  output logic            pop,
  output logic            pulse_out
);

  level_e         lvl;
  logic [TSW-1:0] fall_at;
  logic [TSW-1:0] elapsed;
  logic [TSW-1:0] span;
  logic           due;
  logic           have_next;
  logic           two_held;

  always_comb begin
    elapsed   = now - head_ts;
    two_held  = (fill > CNTW'(1));
    due       = (fill != '0) && (elapsed == TSW'(DELAY_TICKS));
    // Successor may be arriving on the very cycle the head falls due.
    have_next = two_held || push;
    span      = two_held ? (next_ts - head_ts) : elapsed;
  end

  assign pop = due;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl     <= LVL_LOW;
      fall_at <= '0;
    end else if (due && have_next) begin
      lvl     <= LVL_HIGH;
      fall_at <= now + (span >> 1);
    end else if ((lvl == LVL_HIGH) && (now == fall_at)) begin
      lvl <= LVL_LOW;
    end
  end

  assign pulse_out = (lvl == LVL_HIGH);

  // Checker state: length of the current high phase and gap since the last rise.
  logic [TSW-1:0] hi_cnt;
  logic [TSW-1:0] gap_cnt;
  logic           rose_once;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      gap_cnt   <= '0;
      rose_once <= 1'b0;
    end else begin
      hi_cnt <= pulse_out ? hi_cnt + 1'b1 : '0;
      if (due && have_next) begin
        gap_cnt   <= '0;
        rose_once <= 1'b1;
      end else if (gap_cnt != '1) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // High phase never exceeds half of the longest measurable interval.
  p_high_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> (hi_cnt <= TSW'(DELAY_TICKS / 2)));

  // Successive output rises are no closer than the shortest input period.
  p_rise_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (due && have_next && rose_once) |-> (gap_cnt >= TSW'(MIN_TICKS - 1)));

endmodule

// File: rtl/pulse_regen.sv
module pulse_regen #(
  parameter int unsigned TICKS_PER_US  = 1,
  parameter int unsigned MIN_PERIOD_US = 1000,
  parameter int unsigned MAX_PERIOD_US = 2500,
  parameter int          SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic square_out
);

  localparam int unsigned DELAY_TICKS = pr_pkg::us_to_ticks(MAX_PERIOD_US, TICKS_PER_US);
  localparam int unsigned MIN_TICKS   = pr_pkg::us_to_ticks(MIN_PERIOD_US, TICKS_PER_US);
  localparam int          TSW         = $clog2(2 * DELAY_TICKS + 1) + 1;
  localparam int          DEPTH       = int'(pr_pkg::ring_depth(DELAY_TICKS, MIN_TICKS));
  localparam int          CNTW        = $clog2(DEPTH + 1);

  logic            rise;
  logic [TSW-1:0]  now;
  logic            pop;
  logic [TSW-1:0]  head_ts;
  logic [TSW-1:0]  next_ts;
  logic [CNTW-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  pr_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pulse_in),
    .rise (rise)
  );

  pr_stamp_ring #(
    .TSW   (TSW),
    .DEPTH (DEPTH),
    .CNTW  (CNTW)
  ) u_ring (
    .clk     (clk),
    .rst     (rst),
    .push    (rise),
    .push_ts (now),
    .pop     (pop),
    .head_ts (head_ts),
    .next_ts (next_ts),
    .fill    (fill)
  );

  pr_out_sched #(
    .TSW         (TSW),
    .CNTW        (CNTW),
    .DELAY_TICKS (DELAY_TICKS),
    .MIN_TICKS   (MIN_TICKS)
  ) u_sched (
    .clk       (clk),
    .rst       (rst),
    .now       (now),
    .fill      (fill),
    .head_ts   (head_ts),
    .next_ts   (next_ts),
    .push      (rise),
    .pop       (pop),
    .pulse_out (square_out)
  );

  // Checker state: saturating count of edges seen since reset.
  logic [1:0] edges_seen;
  always_ff @(posedge clk) begin
    if (rst)                           edges_seen <= '0;
    else if (rise && edges_seen != 2'd2) edges_seen <= edges_seen + 1'b1;
  end

  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !square_out);

  p_needs_two_edges_r2: assert property (@(posedge clk) disable iff (rst)
    square_out |-> (edges_seen == 2'd2));

endmodule

// File: tb/test_pulse_regen.sv
module test_pulse_regen;

  localparam int D     = 2500;
  localparam int PMIN  = 1000;
  localparam int LAT   = D + 3;
  localparam int QN    = 256;
  localparam int WDOG  = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic square_out;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  string tag = "R1";

  int    exp_rise [QN];
  int    exp_w    [QN];
  string exp_tag  [QN];
  int    wr = 0;
  int    rd = 0;
  int    have_prev = 0;
  int    prev_edge = 0;
  int    rises = 0;
  int    expected_pulses = 0;
  int    rise_at = 0;
  int    cur_w = 0;
  string cur_tag = "";
  logic  prev_out = 1'b0;
  logic  active = 1'b0;

  pulse_regen #(
    .TICKS_PER_US  (1),
    .MIN_PERIOD_US (PMIN),
    .MAX_PERIOD_US (D),
    .SYNC_STAGES   (2)
  ) i_pulse_regen (
    .clk        (clk),
    .rst        (rst),
    .pulse_in   (pulse_in),
    .square_out (square_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Expected output for the interval between two input rises.
  function automatic int half_of(input int span);
    return span / 2;
  endfunction

  task automatic on_edge(input int c);
    if (have_prev != 0 && (c - prev_edge) <= D) begin
      exp_rise[wr % QN] = prev_edge + LAT;
      exp_w[wr % QN]    = half_of(c - prev_edge);
      exp_tag[wr % QN]  = tag;
      wr++;
      expected_pulses++;
    end
    have_prev = 1;
    prev_edge = c;
  endtask

  task automatic pulse(input int period, input int width);
    @(negedge clk);
    pulse_in = 1'b1;
    on_edge(cyc);
    repeat (width) @(negedge clk);
    pulse_in = 1'b0;
    repeat (period - width - 1) @(negedge clk);
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (active) begin
      if (square_out && !prev_out) begin
        rises++;
        if (rd == wr) begin
          check(1'b0, {tag, " R2 R8 unexpected output rise"}, cyc, -1);
        end else begin
          check(cyc == exp_rise[rd % QN],
                {exp_tag[rd % QN], " R3 R5 R9 rise cycle"}, cyc, exp_rise[rd % QN]);
          rise_at = cyc;
          cur_w   = exp_w[rd % QN];
          cur_tag = exp_tag[rd % QN];
          rd++;
        end
      end
      if (!square_out && prev_out) begin
        check((cyc - rise_at) == cur_w, {cur_tag, " R4 R7 high time"}, cyc - rise_at, cur_w);
      end
    end
    prev_out = square_out;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    check(1'b0, "watchdog", cyc, WDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (6) @(negedge clk);
    check(square_out == 1'b0, "R1 low during reset", square_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(square_out == 1'b0, "R1 low after reset", square_out, 0);
    active = 1'b1;

    // R2: a lone edge gives nothing
    tag = "R2";
    pulse(2 * D + 60, 100);
    check(rises == 0, "R2 lone edge produced output", rises, 0);

    // R10: period equal to the latency
    tag = "R10";
    pulse(D, 100);
    pulse(D, 100);
    pulse(D, 100);

    // R7: odd intervals round down
    tag = "R7";
    pulse(1001, 100);
    pulse(1003, 100);
    pulse(1777, 3);

    // R11: minimum-period run fills the edge ring; R6 minimal width
    tag = "R11 R6";
    for (int i = 0; i < 6; i++) pulse(PMIN, 1);

    // R6: wide input pulses
    tag = "R6";
    pulse(1800, 900);
    pulse(1800, 1500);
    pulse(1200, 2);

    // R8: interval one tick too long is suppressed, then recovery
    tag = "R8";
    pulse(D + 1, 100);
    pulse(1500, 100);
    pulse(2000, 100);

    // R9: random run, tick counter wraps several times
    tag = "R9 R5";
    void'($urandom(32'd20151210));
    for (int i = 0; i < 30; i++) begin
      int p;
      int w;
      p = PMIN + int'($urandom % (D - PMIN + 1));
      w = 1 + int'($urandom % 200);
      pulse(p, w);
    end

    // Closing edge, then drain
    tag = "R8";
    pulse(2 * D + 60, 100);
    check(rises == expected_pulses, "R8 R2 total output pulses", rises, expected_pulses);
    check(rd == wr, "R3 pending expectations drained", rd, wr);
    check(square_out == 1'b0, "R8 output idle at end", square_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule